// File: doc/BRIEF.md
# Serial Peripheral Interface Controller

This block moves bytes over a four-pin synchronous serial link, either as the clock-generating master or as a selected slave. Software reaches it through a small register bus. It can write two control registers, a rate register and the data register, and it can read every register plus a status register. A write to the data register starts a transfer. In master mode the block makes the serial clock itself. It shifts eight bits out and eight bits in at the same time, most significant bit first. The clock idles low, and data is sampled on the rising edge and changed on the falling edge.

A status flag reports that a transfer has finished. A second flag reports a data-register write that arrived while a transfer was running. Both flags stay set until software reads the status register and then touches the data register. The finish flag can drive an interrupt line. A single-wire option lets one data pin carry traffic in both directions, with a control bit that picks whether the block drives that pin.

Top module: `spi_ctl`

## Requirements
- R1: After reset every readable register returns 0, and irq, sclk_o, sclk_oe, mosi_oe and miso_oe are all 0.
- R2: While the enable bit (control A bit 6) is 0, a data-register write starts no transfer: sclk_o stays low, and both status flags and irq stay 0.
- R3: In master mode (control A bit 4 = 1), a transfer gives 8 serial clock periods. Each period lasts 2^(n+1) system clocks, where n is the 3-bit rate field in bits 2:0 of the rate register at address 2. The serial clock is high for 2^n clocks of each period and rests low between transfers.
- R4: In master mode, the finish flag (status bit 7 at address 3) is 0 in the clock cycle 16*2^n - 1 cycles after the edge that accepts the data write, and it is 1 one cycle later.
- R5: Data goes out MSB first on mosi_o, which holds bit 7 of the written byte before the first rising serial edge. The byte read back from the data register (address 4) is the byte the peer shifted in, sampled on rising edges.
- R6: Only a status read taken while a flag is set, followed by a read or write of the data register, clears the finish flag. A data access alone, a status read alone, or a status read followed only by accesses to other registers leaves the flag set.
- R7: A data-register write during an active transfer sets the collision flag (status bit 6). It does not change the bits shifted out or the byte received.
- R8: The collision flag clears by the same status-read-then-data-access sequence as the finish flag.
- R9: irq is 1 exactly when the interrupt-enable bit (control A bit 7) and the finish flag are both 1.
- R10: With the single-wire bit (control B bit 0) set, a master drives mosi_o with mosi_oe equal to the drive bit (control B bit 1). When the drive bit is 0, the master takes its input from mosi_i and ignores miso_i.
- R11: In slave mode with ss_n_i low, the block shifts under the external sclk_i. It presents its loaded byte MSB first on miso_o, drives miso_oe only while selected, and sets the finish flag after the 8th rising sclk_i edge, with the received byte in the data register.
- R12: An enabled master drives sclk_oe and mosi_oe high and miso_oe low. A slave never drives sclk_oe or mosi_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address: 0 control A, 1 control B, 2 rate, 3 status, 4 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_o | output | 1 | Master-out data, or the shared pin in single-wire master mode |
| mosi_oe | output | 1 | Output enable for mosi_o |
| mosi_i | input | 1 | Slave data input, or the shared pin input for a single-wire master |
| miso_o | output | 1 | Slave data output |
| miso_oe | output | 1 | Output enable for miso_o |
| miso_i | input | 1 | Master data input, or the shared pin input for a single-wire slave |

## Verification
Several rules are checked on every cycle. The flags can only clear in a cycle that carries a data access. A collision can only appear one cycle after a data write. irq never rises without the finish flag. The serial clock stays low while the block is disabled or in slave mode. Other properties need whole transfers, so only the bench scenarios can show them: the exact cycle the finish flag sets, the shape of the serial clock at each rate, correct full-duplex bytes against a peer model, the collision leaving the transfer intact, the single-wire input path, and slave operation under an external clock.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL_A = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL_B = 3'd1;
   localparam logic [ADDR_W-1:0] A_RATE   = 3'd2;
   localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA   = 3'd4;

   // bit positions inside the control and status registers
   localparam int CA_IE    = 7;
   localparam int CA_EN    = 6;
   localparam int CA_MSTR  = 4;
   localparam int CB_ONEW  = 0;
   localparam int CB_DRIVE = 1;
   localparam int ST_DONE  = 7;
   localparam int ST_WCOL  = 6;

   typedef struct packed {
      logic ie;
      logic en;
      logic master;
      logic one_wire;
      logic drive;
   } spi_cfg_t;
endpackage

// File: rtl/spi_ctl_clkdiv.sv
module spi_ctl_clkdiv #(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int CNT_W = (1 << RATE_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic [CNT_W-1:0] ones;

   always_comb begin
      ones = '1;
      last = ones >> (CNT_W - int'(rate));
      tick = run && (cnt == last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_ctl_flags.sv
module spi_ctl_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic fin,
   input  logic collide,
   input  logic stat_rd,
   input  logic data_acc,
   output logic done,
   output logic wcol
);
   logic armed;
   logic clr;

   assign clr = data_acc && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         done  <= 1'b0;
         wcol  <= 1'b0;
      end else begin
         if (data_acc)                     armed <= 1'b0;
         else if (stat_rd && (done || wcol)) armed <= 1'b1;

         if (fin)      done <= 1'b1;
         else if (clr) done <= 1'b0;

         if (collide)  wcol <= 1'b1;
         else if (clr) wcol <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master,
   input  logic              one_wire,
   input  logic              drive,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              sclk_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   input  logic              miso_i,
   output logic              busy,
   output logic              fin,
   output logic [DATA_W-1:0] rx_data,
   output logic              sclk_o,
   output logic              sclk_oe,
   output logic              mosi_o,
   output logic              mosi_oe,
   output logic              miso_o,
   output logic              miso_oe
);
   localparam int EDGE_W = $clog2(2 * DATA_W);
   localparam int BIT_W  = $clog2(DATA_W);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

   logic master_on, slave_on;
   logic [2:0] raw, synced;
   logic s_sclk, s_ss_n, s_din, s_sclk_prev, s_sel, s_sel_prev, s_rise, s_fall;
   logic m_in, m_busy, sclk_q, in_bit;
   logic [EDGE_W-1:0] edges;
   logic [BIT_W-1:0]  bits;
   logic [DATA_W-1:0] sreg, rx_q, rx_next;

   assign master_on = en && master;
   assign slave_on  = en && !master;
   assign raw       = {sclk_i, ss_n_i, one_wire ? miso_i : mosi_i};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = raw;
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b010;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign synced = stg[SYNC_STAGES-1];
      end
   endgenerate

   assign {s_sclk, s_ss_n, s_din} = synced;
   assign s_sel  = !s_ss_n;
   assign s_rise = s_sclk && !s_sclk_prev;
   assign s_fall = !s_sclk && s_sclk_prev;
   assign m_in   = one_wire ? mosi_i : miso_i;

   always_comb begin
      rx_next = {sreg[DATA_W-2:0], master_on ? in_bit : s_din};
      if (master_on) fin = m_busy && tick && (edges == LAST_EDGE);
      else           fin = slave_on && s_sel && s_rise && (bits == LAST_BIT);
      busy = master_on ? m_busy : (slave_on && s_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_sclk_prev <= 1'b0;
         s_sel_prev  <= 1'b0;
         m_busy      <= 1'b0;
         sclk_q      <= 1'b0;
         in_bit      <= 1'b0;
         edges       <= '0;
         bits        <= '0;
         sreg        <= '0;
         rx_q        <= '0;
      end else begin
         s_sclk_prev <= s_sclk;
         s_sel_prev  <= s_sel;
         if (master_on) begin
            if (m_busy) begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  edges  <= edges + 1'b1;
                  if (!sclk_q) in_bit <= m_in;
                  else         sreg   <= {sreg[DATA_W-2:0], in_bit};
                  if (fin) begin
                     m_busy <= 1'b0;
                     rx_q   <= rx_next;
                  end
               end
            end else if (load) begin
               sreg   <= load_data;
               m_busy <= 1'b1;
               sclk_q <= 1'b0;
               edges  <= '0;
            end
         end else begin
            m_busy <= 1'b0;
            sclk_q <= 1'b0;
            if (slave_on) begin
               if (s_sel && !s_sel_prev) bits <= '0;
               if (load && !s_sel) begin
                  sreg <= load_data;
               end else if (s_sel && s_rise) begin
                  in_bit <= s_din;
                  bits   <= bits + 1'b1;
                  if (fin) rx_q <= rx_next;
               end else if (s_sel && s_fall) begin
                  sreg <= {sreg[DATA_W-2:0], in_bit};
               end
            end
         end
      end
   end

   assign rx_data = rx_q;
   assign sclk_o  = sclk_q;
   assign sclk_oe = master_on;
   assign mosi_o  = sreg[DATA_W-1];
   assign mosi_oe = master_on && (!one_wire || drive);
   assign miso_o  = sreg[DATA_W-1];
   assign miso_oe = slave_on && s_sel && (!one_wire || drive);
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
   import spi_ctl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RATE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sclk_i,
   input  logic              ss_n_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              miso_i
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("spi_ctl: DATA_W must be at least 8");
      end
      if (RATE_W < 1 || RATE_W > 5) begin : g_bad_rate
         $error("spi_ctl: RATE_W must lie in 1..5");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("spi_ctl: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   spi_cfg_t          cfg;
   logic [RATE_W-1:0] rate;
   logic data_acc, data_wr, stat_rd, eng_busy, load, collide;
   logic tick, fin, done, wcol;
   logic [DATA_W-1:0] rx_data;

   assign data_acc = bus_sel && (bus_addr == A_DATA);
   assign data_wr  = data_acc && bus_wr;
   assign stat_rd  = bus_sel && !bus_wr && (bus_addr == A_STATUS);
   assign load     = data_wr && cfg.en && !eng_busy;
   assign collide  = data_wr && cfg.en && eng_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         rate <= '0;
      end else if (bus_sel && bus_wr) begin
         case (bus_addr)
            A_CTRL_A: begin
               cfg.ie     <= bus_wdata[CA_IE];
               cfg.en     <= bus_wdata[CA_EN];
               cfg.master <= bus_wdata[CA_MSTR];
            end
            A_CTRL_B: begin
               cfg.one_wire <= bus_wdata[CB_ONEW];
               cfg.drive    <= bus_wdata[CB_DRIVE];
            end
            A_RATE:  rate <= bus_wdata[RATE_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            A_CTRL_A: begin
               bus_rdata[CA_IE]   = cfg.ie;
               bus_rdata[CA_EN]   = cfg.en;
               bus_rdata[CA_MSTR] = cfg.master;
            end
            A_CTRL_B: begin
               bus_rdata[CB_ONEW]  = cfg.one_wire;
               bus_rdata[CB_DRIVE] = cfg.drive;
            end
            A_RATE:   bus_rdata[RATE_W-1:0] = rate;
            A_STATUS: begin
               bus_rdata[ST_DONE] = done;
               bus_rdata[ST_WCOL] = wcol;
            end
            A_DATA:   bus_rdata = rx_data;
            default:  bus_rdata = '0;
         endcase
      end
   end

   spi_ctl_clkdiv #(.RATE_W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n),
      .run(eng_busy && cfg.en && cfg.master),
      .rate(rate), .tick(tick)
   );

   spi_ctl_engine #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .en(cfg.en), .master(cfg.master), .one_wire(cfg.one_wire), .drive(cfg.drive),
      .tick(tick), .load(load), .load_data(bus_wdata),
      .sclk_i(sclk_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_i(miso_i),
      .busy(eng_busy), .fin(fin), .rx_data(rx_data),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_o(miso_o), .miso_oe(miso_oe)
   );

   spi_ctl_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .fin(fin), .collide(collide), .stat_rd(stat_rd), .data_acc(data_acc),
      .done(done), .wcol(wcol)
   );

   assign irq = cfg.ie && done;
endmodule

// File: rtl/spi_ctl_checker.sv
module spi_ctl_checker (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic master,
   input logic done,
   input logic wcol,
   input logic irq,
   input logic sclk_o,
   input logic data_acc,
   input logic data_wr
);
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> !sclk_o); // R2
   AST_SLAVE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!master && $past(!master)) |-> !sclk_o); // R12
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !data_acc) |=> done); // R6
   AST_DONE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(data_acc)); // R6
   AST_WCOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol) |-> $past(data_wr)); // R7
   AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol && !data_acc) |=> wcol); // R8
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done); // R9
endmodule

bind spi_ctl spi_ctl_checker u_chk (
   .clk(clk), .rst_n(rst_n), .en(cfg.en), .master(cfg.master),
   .done(done), .wcol(wcol), .irq(irq), .sclk_o(sclk_o),
   .data_acc(data_acc), .data_wr(data_wr)
);

// File: tb/spi_ctl_test.sv
module spi_ctl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] CA = 3'd0, CB = 3'd1, RT = 3'd2, ST = 3'd3, DT = 3'd4;

   logic clk = 0, rst_n = 0;
   logic bus_sel = 0, bus_wr = 0;
   logic [2:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
   logic sclk_i = 0, ss_n_i = 1, bm_mosi = 0;
   logic slave_test = 0, miso_junk = 0;
   logic [7:0] sm_sreg = 0;
   logic sm_bit = 0;
   logic mosi_i, miso_i;
   int checks = 0, errors = 0;

   assign mosi_i = slave_test ? bm_mosi : sm_sreg[7];
   assign miso_i = miso_junk ? 1'b0 : sm_sreg[7];

   spi_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // peer model for master-mode transfers: clock idles low, sample on rise, shift on fall
   always @(posedge sclk_o) sm_bit = mosi_o;
   always @(negedge sclk_o) sm_sreg = {sm_sreg[6:0], sm_bit};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_w(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_r(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0;
   endtask

   function automatic int finish_cycles(input int rate);
      return 16 * (1 << rate);
   endfunction

   // master transfer, timed against the expected finish cycle (irq enabled by caller)
   task automatic m_xfer(input logic [7:0] tx, input logic [7:0] peer, input int rate,
                         output logic [7:0] rx, output logic [7:0] peer_got);
      int h, hi, rises;
      logic prev, first;
      logic [7:0] s;
      h = 1 << rate; hi = 0; rises = 0; prev = 0;
      sm_sreg = peer;
      bus_w(DT, tx);
      for (int k = 1; k <= finish_cycles(rate); k++) begin
         @(negedge clk);
         if (k == 1) begin
            first = mosi_o;
            check(first == tx[7], "R5 msb first", first, tx[7]);
         end
         if (sclk_o) hi++;
         if (sclk_o && !prev) rises++;
         prev = sclk_o;
         if (k == finish_cycles(rate) - 1) check(irq == 0, "R4 early", irq, 0);
         if (k == finish_cycles(rate))     check(irq == 1, "R4 on time", irq, 1);
      end
      check(hi == 8 * h, "R3 high time", hi, 8 * h);
      check(rises == 8, "R3 clock count", rises, 8);
      bus_r(ST, s);
      check(s[7] == 1, "R4 status done", s, 8'h80);
      bus_r(DT, rx);
      peer_got = sm_sreg;
      check(irq == 0, "R6 cleared by sequence", irq, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] d, rx, got, tx, peer, mb, sb;
      int rate;
      void'($urandom(32'h1badcafe));
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         bus_r(3'(a), d);
         check(d == 0, "R1 reset register", d, 0);
      end
      check({irq, sclk_o, sclk_oe, mosi_oe, miso_oe} == 0, "R1 reset outputs",
            {irq, sclk_o, sclk_oe, mosi_oe, miso_oe}, 0);

      // R2 disabled: master + irq enable, but enable bit clear
      bus_w(CA, 8'h90);
      bus_w(DT, 8'h11);
      begin
         int seen = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sclk_o || irq) seen++;
         end
         check(seen == 0, "R2 no activity while disabled", seen, 0);
      end
      bus_r(ST, d);
      check(d == 0, "R2 flags stay clear", d, 0);

      // R12 master pin drive
      bus_w(CA, 8'hD0);
      @(negedge clk);
      check({sclk_oe, mosi_oe, miso_oe} == 3'b110, "R12 master enables",
            {sclk_oe, mosi_oe, miso_oe}, 3'b110);

      // R3 R4 R5 R9 directed corners: slowest tested and fastest rate
      bus_w(RT, 8'd0);
      m_xfer(8'h80, 8'h01, 0, rx, got);
      check(rx == 8'h01, "R5 rx rate0", rx, 8'h01);
      check(got == 8'h80, "R5 peer rx rate0", got, 8'h80);
      bus_w(RT, 8'd4);
      m_xfer(8'hC3, 8'h3C, 4, rx, got);
      check(rx == 8'h3C, "R5 rx rate4", rx, 8'h3C);
      check(got == 8'hC3, "R5 peer rx rate4", got, 8'hC3);

      // random full-duplex transfers
      for (int i = 0; i < 16; i++) begin
         rate = $urandom % 4;
         tx = 8'($urandom); peer = 8'($urandom);
         bus_w(RT, 8'(rate));
         m_xfer(tx, peer, rate, rx, got);
         check(rx == peer, "R5 random rx", rx, peer);
         check(got == tx, "R5 random peer rx", got, tx);
      end

      // R9 interrupt enable off: flag sets without irq
      bus_w(CA, 8'h50);
      bus_w(RT, 8'd0);
      sm_sreg = 8'h77;
      bus_w(DT, 8'h12);
      repeat (20) @(negedge clk);
      check(irq == 0, "R9 irq masked", irq, 0);
      bus_r(ST, d);
      check(d[7] == 1, "R9 flag set while masked", d, 8'h80);
      bus_w(CA, 8'hD0);
      @(negedge clk);
      check(irq == 1, "R9 irq follows enable", irq, 1);
      bus_r(DT, d);

      // R7 R8 R6 collision and clearing sequence
      bus_w(RT, 8'd2);
      sm_sreg = 8'h5A;
      bus_w(DT, 8'h96);
      repeat (10) @(negedge clk);
      bus_w(DT, 8'hFF);
      repeat (80) @(negedge clk);
      got = sm_sreg;
      bus_r(DT, rx);
      check(rx == 8'h5A, "R7 rx intact", rx, 8'h5A);
      check(got == 8'h96, "R7 tx intact", got, 8'h96);
      bus_r(ST, d);
      check(d[7:6] == 2'b11, "R6 data access alone keeps flags", d, 8'hC0);
      bus_r(ST, d);
      check(d[7:6] == 2'b11, "R6 status read alone keeps flags", d, 8'hC0);
      bus_w(RT, 8'd2);
      bus_r(ST, d);
      check(d[7:6] == 2'b11, "R8 other register keeps flags", d, 8'hC0);
      bus_r(DT, d);
      bus_r(ST, d);
      check(d[7:6] == 2'b00, "R8 sequence clears both", d, 0);

      // R10 single-wire master, driving then receiving
      bus_w(CB, 8'h03);
      bus_w(RT, 8'd1);
      m_xfer(8'hA7, 8'h00, 1, rx, got);
      check(mosi_oe == 1, "R10 drives shared pin", mosi_oe, 1);
      check(got == 8'hA7, "R10 tx on shared pin", got, 8'hA7);
      bus_w(CB, 8'h01);
      miso_junk = 1;
      @(negedge clk);
      check(mosi_oe == 0, "R10 releases shared pin", mosi_oe, 0);
      m_xfer(8'h0F, 8'hB4, 1, rx, got);
      check(rx == 8'hB4, "R10 rx from shared pin", rx, 8'hB4);
      miso_junk = 0;
      bus_w(CB, 8'h00);

      // R11 R12 slave mode under an external clock
      slave_test = 1;
      bus_w(CA, 8'hC0);
      bus_w(DT, 8'h3C);
      @(negedge clk);
      check({sclk_oe, mosi_oe, miso_oe} == 0, "R12 slave idle drives nothing",
            {sclk_oe, mosi_oe, miso_oe}, 0);
      mb = 8'hE1; sb = 0;
      ss_n_i = 0;
      repeat (8) @(negedge clk);
      check(miso_oe == 1, "R11 miso driven when selected", miso_oe, 1);
      for (int b = 7; b >= 0; b--) begin
         bm_mosi = mb[b];
         repeat (8) @(negedge clk);
         sclk_i = 1;
         sb = {sb[6:0], miso_o};
         repeat (8) @(negedge clk);
         sclk_i = 0;
      end
      repeat (8) @(negedge clk);
      check({sclk_oe, mosi_oe} == 0, "R12 slave no clock drive", {sclk_oe, mosi_oe}, 0);
      ss_n_i = 1;
      repeat (6) @(negedge clk);
      check(miso_oe == 0, "R11 miso released", miso_oe, 0);
      check(irq == 1, "R11 finish flag", irq, 1);
      check(sb == 8'h3C, "R11 slave tx", sb, 8'h3C);
      bus_r(ST, d);
      bus_r(DT, rx);
      check(rx == mb, "R11 slave rx", rx, mb);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule